// File: doc/BRIEF.md
# Field-Dependent Vertical Phase Offset Selector

This block sits in front of a vertical scaler. At each output field start it picks one of four programmed vertical phase offset pairs, each a luma offset and a chroma offset. The pick depends on two bits: the parity of the detected input field and a task status bit. The chosen pair is registered and stays fixed for the whole field, so the scaler sees one phase for every line of that field.

The block also registers an output field ID for the back-end. A source-select control sets where that ID comes from: the detected input field ID or the task status bit. The back-end can treat either ID value as the upper output lines. Together with the source select, this covers the three usual combinations of upper/lower line mapping. The offset values come from elsewhere and may change at any time. A change only reaches the outputs at the next field start.

Top module: `vpo_phase_select`

## Requirements
- R1: While reset is asserted, and after reset until the first field-start strobe, luma_phase_o, chroma_phase_o and out_fid_o are all zero.
- R2: On a field-start strobe, the pair index is in_fid_i*2 + task_bit_i. Index 0 is upper lines with task 0, 1 is upper with task 1, 2 is lower with task 0, and 3 is lower with task 1. In each bus, pair k occupies bits [8k+7:8k].
- R3: The luma offset and the chroma offset output together always come from the same pair index.
- R4: With fid_src_i = 0 at a strobe, out_fid_o takes in_fid_i (0 = upper lines, 1 = lower lines).
- R5: With fid_src_i = 1 at a strobe, out_fid_o takes task_bit_i.
- R6: Outputs change only in the cycle after a field-start strobe. Changes on in_fid_i, task_bit_i or fid_src_i between strobes have no effect on the outputs.
- R7: Offset bus values written between strobes do not reach the outputs until the next strobe, and then they do.
- R8: Back-to-back strobes on consecutive cycles each reload the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| field_start_i | input | 1 | One-cycle strobe at output field start |
| in_fid_i | input | 1 | Detected input field ID (0 upper, 1 lower) |
| task_bit_i | input | 1 | Task status bit |
| fid_src_i | input | 1 | Output ID source: 0 input field ID, 1 task bit |
| luma_ofs_i | input | 32 | Four packed luma phase offsets, pair k at [8k+7:8k] |
| chroma_ofs_i | input | 32 | Four packed chroma phase offsets, pair k at [8k+7:8k] |
| luma_phase_o | output | 8 | Latched luma phase offset |
| chroma_phase_o | output | 8 | Latched chroma phase offset |
| out_fid_o | output | 1 | Latched output field ID |

## Verification
The bench walks all eight combinations of input field ID, task bit and source select at a strobe. Each offset byte in the table is distinct, so a swapped index bit or a luma/chroma mismatch shows up directly. The two source settings are applied with input field ID and task bit set to opposite values, which separates the two ID sources. Directed cases toggle inputs and rewrite offsets between strobes to confirm the frozen-field behaviour, and they also fire back-to-back strobes.

// File: rtl/vpo_pkg.sv
package vpo_pkg;
  localparam int unsigned N_PAIR = 4;
  localparam int unsigned IDX_W  = $clog2(N_PAIR);

  typedef enum logic {
    FID_FROM_INPUT = 1'b0,
    FID_FROM_TASK  = 1'b1
  } fid_src_e;
endpackage

// File: rtl/vpo_index_enc.sv
module vpo_index_enc
  import vpo_pkg::*;
(
  input  logic             in_fid_i,
  input  logic             task_bit_i,
  output logic [IDX_W-1:0] idx_o
);
  // parity is the high bit, task the low bit
  assign idx_o = {in_fid_i, task_bit_i};
endmodule

// File: rtl/vpo_pair_mux.sv
module vpo_pair_mux
  import vpo_pkg::*;
#(
  parameter int unsigned PH_W = 8
) (
  input  logic [N_PAIR*PH_W-1:0] luma_bus_i,
  input  logic [N_PAIR*PH_W-1:0] chroma_bus_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [PH_W-1:0]        luma_o,
  output logic [PH_W-1:0]        chroma_o
);
  logic [PH_W-1:0] luma_arr   [N_PAIR];
  logic [PH_W-1:0] chroma_arr [N_PAIR];

  for (genvar k = 0; k < N_PAIR; k++) begin : g_unpack
    assign luma_arr[k]   = luma_bus_i[k*PH_W +: PH_W];
    assign chroma_arr[k] = chroma_bus_i[k*PH_W +: PH_W];
  end

  always_comb begin
    luma_o   = '0;
    chroma_o = '0;
    for (int k = 0; k < N_PAIR; k++) begin
      if (idx_i == IDX_W'(k)) begin
        luma_o   = luma_arr[k];
        chroma_o = chroma_arr[k];
      end
    end
  end
endmodule

// File: rtl/vpo_field_reg.sv
module vpo_field_reg #(
  parameter int unsigned PH_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [PH_W-1:0] luma_d_i,
  input  logic [PH_W-1:0] chroma_d_i,
  input  logic            fid_d_i,
  output logic [PH_W-1:0] luma_q_o,
  output logic [PH_W-1:0] chroma_q_o,
  output logic            fid_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      luma_q_o   <= '0;
      chroma_q_o <= '0;
      fid_q_o    <= 1'b0;
    end else if (load_i) begin
      luma_q_o   <= luma_d_i;
      chroma_q_o <= chroma_d_i;
      fid_q_o    <= fid_d_i;
    end
  end

  a_r6_hold_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(luma_q_o) && $stable(chroma_q_o) && $stable(fid_q_o));
endmodule

// File: rtl/vpo_phase_select.sv
module vpo_phase_select
  import vpo_pkg::*;
#(
  parameter int unsigned PH_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   field_start_i,
  input  logic                   in_fid_i,
  input  logic                   task_bit_i,
  input  logic                   fid_src_i,
  input  logic [N_PAIR*PH_W-1:0] luma_ofs_i,
  input  logic [N_PAIR*PH_W-1:0] chroma_ofs_i,
  output logic [PH_W-1:0]        luma_phase_o,
  output logic [PH_W-1:0]        chroma_phase_o,
  output logic                   out_fid_o
);
  logic [IDX_W-1:0] idx;
  logic [PH_W-1:0]  luma_sel;
  logic [PH_W-1:0]  chroma_sel;
  logic             fid_sel;
  fid_src_e         src;

  assign src = fid_src_e'(fid_src_i);

  vpo_index_enc u_idx (
    .in_fid_i   (in_fid_i),
    .task_bit_i (task_bit_i),
    .idx_o      (idx)
  );

  vpo_pair_mux #(.PH_W(PH_W)) u_mux (
    .luma_bus_i   (luma_ofs_i),
    .chroma_bus_i (chroma_ofs_i),
    .idx_i        (idx),
    .luma_o       (luma_sel),
    .chroma_o     (chroma_sel)
  );

  always_comb begin
    unique case (src)
      FID_FROM_TASK:  fid_sel = task_bit_i;
      default:        fid_sel = in_fid_i;
    endcase
  end

  vpo_field_reg #(.PH_W(PH_W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (field_start_i),
    .luma_d_i   (luma_sel),
    .chroma_d_i (chroma_sel),
    .fid_d_i    (fid_sel),
    .luma_q_o   (luma_phase_o),
    .chroma_q_o (chroma_phase_o),
    .fid_q_o    (out_fid_o)
  );

  // R2, R3: both outputs come from the pair picked by parity and task bit
  a_r2_luma_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_i |=> luma_phase_o ==
      $past(luma_ofs_i[{in_fid_i, task_bit_i}*PH_W +: PH_W]));
  a_r3_chroma_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_i |=> chroma_phase_o ==
      $past(chroma_ofs_i[{in_fid_i, task_bit_i}*PH_W +: PH_W]));
  a_r4_fid_from_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_i && !fid_src_i |=> out_fid_o == $past(in_fid_i));
  a_r5_fid_from_task: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_i && fid_src_i |=> out_fid_o == $past(task_bit_i));
endmodule

// File: tb/vpo_phase_select_tb.sv
module vpo_phase_select_tb;
  localparam int unsigned PH_W = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        field_start_i = 1'b0;
  logic        in_fid_i = 1'b0;
  logic        task_bit_i = 1'b0;
  logic        fid_src_i = 1'b0;
  logic [31:0] luma_ofs_i = 32'h4D3C2B1A;
  logic [31:0] chroma_ofs_i = 32'hD4C3B2A1;
  logic [7:0]  luma_phase_o;
  logic [7:0]  chroma_phase_o;
  logic        out_fid_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  vpo_phase_select #(.PH_W(PH_W)) u_dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .field_start_i  (field_start_i),
    .in_fid_i       (in_fid_i),
    .task_bit_i     (task_bit_i),
    .fid_src_i      (fid_src_i),
    .luma_ofs_i     (luma_ofs_i),
    .chroma_ofs_i   (chroma_ofs_i),
    .luma_phase_o   (luma_phase_o),
    .chroma_phase_o (chroma_phase_o),
    .out_fid_o      (out_fid_o)
  );

  // vector: {in_fid, task_bit, fid_src}
  localparam logic [2:0] VEC [8] = '{3'b000, 3'b010, 3'b100, 3'b110,
                                     3'b001, 3'b011, 3'b101, 3'b111};

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] expect_of(input logic [31:0] lb, input logic [31:0] cb,
                                            input logic f, input logic t, input logic s);
    int k = (f ? 2 : 0) + (t ? 1 : 0);
    return {(s ? t : f), lb[k*8 +: 8], cb[k*8 +: 8]};
  endfunction

  task automatic strobe(input logic f, input logic t, input logic s);
    @(negedge clk_i);
    in_fid_i = f; task_bit_i = t; fid_src_i = s; field_start_i = 1'b1;
    @(negedge clk_i);
    field_start_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [16:0] held;
    #1;
    check("R1 in reset", {out_fid_o, luma_phase_o, chroma_phase_o}, 17'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    in_fid_i = 1'b1; task_bit_i = 1'b1; fid_src_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 after reset no strobe", {out_fid_o, luma_phase_o, chroma_phase_o}, 17'h0);

    for (int i = 0; i < 8; i++) begin
      strobe(VEC[i][2], VEC[i][1], VEC[i][0]);
      check($sformatf("R2 R3 R4 R5 vec %0d", i), {out_fid_o, luma_phase_o, chroma_phase_o},
            expect_of(luma_ofs_i, chroma_ofs_i, VEC[i][2], VEC[i][1], VEC[i][0]));
    end

    // R6: last strobe was f=1,t=1,s=1 -> flip everything, no strobe
    held = {out_fid_o, luma_phase_o, chroma_phase_o};
    in_fid_i = 1'b0; task_bit_i = 1'b0; fid_src_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check("R6 inputs ignored between strobes", {out_fid_o, luma_phase_o, chroma_phase_o}, held);

    // R7: rewrite offsets mid-field
    luma_ofs_i = 32'h99887766; chroma_ofs_i = 32'h55443322;
    repeat (3) @(negedge clk_i);
    check("R7 offsets held until strobe", {out_fid_o, luma_phase_o, chroma_phase_o}, held);
    strobe(1'b1, 1'b0, 1'b0);
    check("R7 new offsets at strobe", {out_fid_o, luma_phase_o, chroma_phase_o},
          {1'b1, 8'h88, 8'h44});

    // R8: back-to-back strobes
    @(negedge clk_i);
    in_fid_i = 1'b0; task_bit_i = 1'b1; fid_src_i = 1'b1; field_start_i = 1'b1;
    @(negedge clk_i);
    check("R8 first of pair", {out_fid_o, luma_phase_o, chroma_phase_o}, {1'b1, 8'h77, 8'h33});
    in_fid_i = 1'b0; task_bit_i = 1'b0; fid_src_i = 1'b0;
    @(negedge clk_i);
    field_start_i = 1'b0;
    check("R8 second of pair", {out_fid_o, luma_phase_o, chroma_phase_o}, {1'b0, 8'h66, 8'h22});

    // R4 vs R5 with opposite source values
    strobe(1'b0, 1'b1, 1'b0);
    check("R4 input fid chosen", {16'h0, out_fid_o}, 17'h0);
    strobe(1'b0, 1'b1, 1'b1);
    check("R5 task bit chosen", {16'h0, out_fid_o}, 17'h1);

    // R1 again: reset mid-run clears outputs
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset clears", {out_fid_o, luma_phase_o, chroma_phase_o}, 17'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule